// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit sits between the transfer engine of an I2C controller and its register interface. The engine and the FIFOs report single-cycle event pulses. The unit latches each pulse into a sticky status bit. Software reads the status word and clears handled bits by writing ones to them. An interrupt line is formed from the status bits that are also set in an interrupt enable mask.

For older software, a vector register returns a small code for the highest-priority pending event. Reading the vector clears the event it names, so a handler can service events one at a time without writing to the status word.

A separate wakeup enable mask selects the sources that raise a wakeup request. Its bit layout overlaps the interrupt mask only in part. It also takes three sources that are not status bits: bus free, start condition and general call.

Register selects are shared by the read and write strobes: 0 = status, 1 = interrupt enable, 2 = wakeup enable, 3 = vector. The vector is read-only.

Top module: `irq_status_unit`

## Requirements
- R1: An event pulse on `evt_in` sets the matching sticky status bit, and the bit is visible on a status read in the next cycle. The sticky bits are: transmit drain 14, receive drain 13, receive overrun 11, transmit underflow 10, addressed as slave 9, address zero 8, transmit ready 4, receive ready 3, access ready 2, no-acknowledge 1, arbitration lost 0. A status bit never becomes set without a pulse.
- R2: Status bit 12 always reads the live level of `bus_busy`, and a write to it has no effect. Status bits 15, 7, 6 and 5 read 0.
- R3: A status write (select 0) clears every sticky bit written as 1 and leaves every bit written as 0 unchanged.
- R4: A pulse that arrives in the same cycle as a clear of its bit leaves the bit set. This holds for a clear by status write and for a clear by vector read.
- R5: The interrupt enable register (select 1) stores bits 14, 13, 4, 3, 2, 1 and 0. Its other bits read 0.
- R6: `irq` is a register. It is 1 in the cycle after some status bit and its enable bit are both set, and 0 in the cycle after no such pair exists.
- R7: A vector read (select 3) returns a code in bits 2:0. The code is 1 for arbitration lost, 2 for no-acknowledge, 3 for access ready, 4 for receive ready and 5 for transmit ready. When several of these are pending, the lowest code wins. The code is 0 when none is pending. The code ignores the interrupt enable mask.
- R8: A vector read clears only the status bit it reports. A vector read that returns 0 and a status read leave the status unchanged.
- R9: The wakeup enable register (select 2) stores bits 14, 13, 9, 8, 6, 5, 3, 2, 1 and 0, and its other bits read 0. `wake_req` is a register that is 1 in the cycle after an enabled source is active. The sources are: status bits 14, 13, 9, 2, 1 and 0 at their own positions; `bus_free_evt` at 8; `start_evt` at 6; `gcall_evt` at 5; and transmit ready or receive ready together at 3.
- R10: After reset all status bits, both masks, `irq` and `wake_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 16 | Single-cycle event pulses, one per status position |
| bus_busy | input | 1 | Live bus busy level, shown in status bit 12 |
| bus_free_evt | input | 1 | Bus free pulse, wakeup source only |
| start_evt | input | 1 | Start condition pulse, wakeup source only |
| gcall_evt | input | 1 | General call pulse, wakeup source only |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; a vector read clears the reported event |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 16 | Read data for the selected register, valid in the strobe cycle |
| irq | output | 1 | Registered interrupt request |
| wake_req | output | 1 | Registered wakeup request |

## Verification
The bench targets the cases where a clear and a set meet in the same cycle. A design in which the clear wins would lose an event, and the bench would read a zero where a one is expected after a write or a vector read coincides with a pulse.

It walks the vector through every code with all five events pending. This exposes a wrong priority order, a read that clears more than one bit, or a code-0 read that disturbs state.

It counts the cycles from a status change to `irq` and `wake_req`, so an unregistered or late output is caught. It also checks that an event without its enable bit, or a wakeup source without its mask bit, stays silent. Bus busy is checked as a live level that a write cannot clear.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_in,
  input  logic          bus_busy,
  input  logic          bus_free_evt,
  input  logic          start_evt,
  input  logic          gcall_evt,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          wake_req
);

  localparam logic [DW-1:0] STICKY_M = DW'(16'h6F1F);
  localparam logic [DW-1:0] IEN_M    = DW'(16'h601F);
  localparam logic [DW-1:0] WEN_M    = DW'(16'h636F);
  localparam int            BB_POS   = 12;
  localparam int            NVEC     = 5;

  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_IEN  = 2'd1;
  localparam logic [1:0] SEL_WEN  = 2'd2;
  localparam logic [1:0] SEL_VEC  = 2'd3;

  logic [DW-1:0] st_q, ien_q, wen_q;
  logic [DW-1:0] vec_clr, clr_mask, wsrc;
  logic [2:0]    vcode;

  always_comb begin
    vcode   = 3'd0;
    vec_clr = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (st_q[i]) begin
        vcode   = 3'(i + 1);
        vec_clr = DW'(1) << i;
      end
    end
  end

  assign clr_mask = ((wr_en && wr_sel == SEL_STAT) ? wr_data : '0)
                  | ((rd_en && rd_sel == SEL_VEC)  ? vec_clr : '0);

  assign wsrc = {1'b0, st_q[14:13], 3'b000, st_q[9], bus_free_evt, 1'b0,
                 start_evt, gcall_evt, 1'b0, st_q[4] | st_q[3], st_q[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= '0;
      ien_q    <= '0;
      wen_q    <= '0;
      irq      <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      st_q <= ((st_q & ~clr_mask) | evt_in) & STICKY_M;
      if (wr_en && wr_sel == SEL_IEN) ien_q <= wr_data & IEN_M;
      if (wr_en && wr_sel == SEL_WEN) wen_q <= wr_data & WEN_M;
      irq      <= |(st_q & ien_q);
      wake_req <= |(wsrc & wen_q);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (rd_sel)
        SEL_STAT: begin
          rd_data         = st_q;
          rd_data[BB_POS] = bus_busy;
        end
        SEL_IEN:  rd_data = ien_q;
        SEL_WEN:  rd_data = wen_q;
        default:  rd_data = DW'(vcode);
      endcase
    end
  end

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_in & STICKY_M)) |=> ((st_q & $past(evt_in & STICKY_M)) == $past(evt_in & STICKY_M))); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~$past(st_q) & ~$past(evt_in)) == '0)); // R1

  AST_W1C_AL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_STAT && wr_data[0] && !evt_in[0]) |=> !st_q[0]); // R3

  AST_VEC_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_VEC && (|st_q[4:0]) && !(|evt_in[4:0]) && !(wr_en && wr_sel == SEL_STAT))
    |=> ($countones(st_q[4:0]) + 1 == $countones($past(st_q[4:0])))); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(st_q & ien_q)) |=> !irq); // R6

  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(wsrc & wen_q)) |=> !wake_req); // R9

endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_in = '0;
  logic        bus_busy = 1'b0, bus_free_evt = 1'b0, start_evt = 1'b0, gcall_evt = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_sel = '0, rd_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq, wake_req;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] v;
    string       tag;
  } exp_t;
  exp_t expq[$];

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_busy(bus_busy),
    .bus_free_evt(bus_free_evt), .start_evt(start_evt), .gcall_evt(gcall_evt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq), .wake_req(wake_req)
  );

  always #10 clk = ~clk;

  task automatic step(input logic [15:0] e, input logic w, input logic [1:0] ws,
                      input logic [15:0] wd, input logic r, input logic [1:0] rs,
                      input logic [15:0] ev, input string tag);
    exp_t it;
    @(posedge clk); #2;
    evt_in = e; wr_en = w; wr_sel = ws; wr_data = wd; rd_en = r; rd_sel = rs;
    if (r) begin
      it.v = ev;
      it.tag = tag;
      expq.push_back(it);
    end
  endtask

  task automatic idle();
    step('0, 1'b0, 2'd0, '0, 1'b0, 2'd0, '0, "");
  endtask

  task automatic rd(input logic [1:0] s, input logic [15:0] ev, input string tag);
    step('0, 1'b0, 2'd0, '0, 1'b1, s, ev, tag);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    step('0, 1'b1, s, d, 1'b0, 2'd0, '0, "");
  endtask

  task automatic chk(input logic act, input logic ev, input string tag);
    checks++;
    if (act !== ev) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, ev);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      exp_t it;
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: got %h expected no read", rd_data);
      end else begin
        it = expq.pop_front();
        if (rd_data !== it.v) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, rd_data, it.v);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    rd(2'd0, 16'h0000, "R10 status after reset");
    rd(2'd1, 16'h0000, "R10 irq enable after reset");
    rd(2'd2, 16'h0000, "R10 wake enable after reset");
    rd(2'd3, 16'h0000, "R10 vector after reset");
    idle();
    @(negedge clk);
    chk(irq, 1'b0, "R10 irq after reset");
    chk(wake_req, 1'b0, "R10 wake after reset");

    bus_busy = 1'b1;
    rd(2'd0, 16'h1000, "R2 bus busy live high");
    wr(2'd0, 16'h1000);
    rd(2'd0, 16'h1000, "R2 write to bus busy ignored");
    idle();
    bus_busy = 1'b0;
    rd(2'd0, 16'h0000, "R2 bus busy live low");

    step(16'hFFFF, 1'b0, 2'd0, '0, 1'b0, 2'd0, '0, "");
    rd(2'd0, 16'h6F1F, "R1 all events latched, unused bits zero");
    idle();
    rd(2'd0, 16'h6F1F, "R1 bits are sticky");

    wr(2'd0, 16'h0F00);
    rd(2'd0, 16'h601F, "R3 ones clear");
    wr(2'd0, 16'h0000);
    rd(2'd0, 16'h601F, "R3 zeros leave bits");

    rd(2'd3, 16'd1, "R7 arbitration lost first");
    rd(2'd3, 16'd2, "R7 no-acknowledge second");
    rd(2'd3, 16'd3, "R7 access ready third");
    rd(2'd3, 16'd4, "R7 receive ready fourth");
    rd(2'd3, 16'd5, "R7 transmit ready fifth");
    rd(2'd3, 16'd0, "R7 none pending");
    rd(2'd0, 16'h6000, "R8 vector cleared only reported bits");

    step(16'h2000, 1'b1, 2'd0, 16'h6000, 1'b0, 2'd0, '0, "");
    rd(2'd0, 16'h2000, "R4 event wins over write clear");
    step(16'h0001, 1'b0, 2'd0, '0, 1'b0, 2'd0, '0, "");
    step(16'h0001, 1'b0, 2'd0, '0, 1'b1, 2'd3, 16'd1, "R4 vector read with new event");
    rd(2'd0, 16'h2001, "R4 event wins over vector read");
    wr(2'd0, 16'hFFFF);
    rd(2'd0, 16'h0000, "R3 clear all");

    wr(2'd1, 16'hFFFF);
    rd(2'd1, 16'h601F, "R5 enable mask bits");
    wr(2'd1, 16'h0004);
    rd(2'd1, 16'h0004, "R5 enable written value");
    step(16'h0008, 1'b0, 2'd0, '0, 1'b0, 2'd0, '0, "");
    idle();
    idle();
    @(negedge clk);
    chk(irq, 1'b0, "R6 disabled event gives no irq");
    step(16'h0004, 1'b0, 2'd0, '0, 1'b0, 2'd0, '0, "");
    idle();
    @(negedge clk);
    chk(irq, 1'b0, "R6 irq not yet in status cycle");
    idle();
    @(negedge clk);
    chk(irq, 1'b1, "R6 irq one cycle after status");
    wr(2'd0, 16'h0004);
    idle();
    @(negedge clk);
    chk(irq, 1'b1, "R6 irq held one cycle after clear");
    idle();
    @(negedge clk);
    chk(irq, 1'b0, "R6 irq drops");
    wr(2'd0, 16'hFFFF);

    wr(2'd2, 16'hFFFF);
    rd(2'd2, 16'h636F, "R9 wake mask bits");
    wr(2'd2, 16'h0040);
    idle();
    start_evt = 1'b1;
    idle();
    start_evt = 1'b0;
    @(negedge clk);
    chk(wake_req, 1'b1, "R9 start condition wakes");
    idle();
    @(negedge clk);
    chk(wake_req, 1'b0, "R9 wake follows pulse");
    gcall_evt = 1'b1;
    idle();
    gcall_evt = 1'b0;
    @(negedge clk);
    chk(wake_req, 1'b0, "R9 disabled source silent");
    wr(2'd2, 16'h0008);
    step(16'h0010, 1'b0, 2'd0, '0, 1'b0, 2'd0, '0, "");
    idle();
    idle();
    @(negedge clk);
    chk(wake_req, 1'b1, "R9 transmit ready maps to data ready");

    idle();
    idle();
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", expq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule